// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns the burst fields of a latched SDRAM mode register into the column address sequence of each read or write burst. When a start pulse arrives, the block captures the starting column, the access direction and the burst settings in force at that moment. From the next cycle it emits one column per cycle, each marked by a valid strobe. The final column carries a last-beat flag.

The burst length is 1, 2, 4, 8 or a full row of 256 columns. Columns are ordered either sequentially, wrapping inside the aligned block, or interleaved, where the beat count is XORed into the low bits. A full-row burst runs until a terminate input stops it. One mode bit makes writes single-beat, while reads keep the programmed length. A mode setting that is reserved or illegal raises an error flag, and the burst then runs as a single beat.

Top module: `sdram_burst_colgen`

## Requirements
- R1: Mode bits [2:0] set the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a full row of 256 columns.
- R2: The first valid beat appears on the cycle after `start` is sampled high, and its column equals `start_col`.
- R3: With mode bit 3 at 0 (sequential) and length L, beat k carries column (start & ~(L-1)) | ((start + k) & (L-1)).
- R4: With mode bit 3 at 1 (interleaved) and length L, beat k carries column start ^ k, where k < L.
- R5: A full-row burst increments modulo 256 and continues indefinitely. A cycle in which `stop` is high is its last beat, and `col_valid` is low on the next cycle.
- R6: When mode bit 9 is 1, a write burst (`wr` = 1) is a single beat. A read keeps the programmed length.
- R7: Length codes 100, 101 and 110, and code 111 combined with mode bit 3 at 1, set `mode_err` high and give a single-beat burst. A legal setting clears `mode_err`, which is updated at every start.
- R8: `last_beat` is high only on the final valid beat. On the following cycle `col_valid` is low unless a new start was sampled.
- R9: After reset, `col_valid`, `last_beat` and `mode_err` are low.
- R10: A start sampled during a burst abandons that burst. The new burst begins on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_reg | input | 12 | Latched mode register value |
| start | input | 1 | Begin a burst this cycle |
| start_col | input | 8 | Starting column of the burst |
| wr | input | 1 | 1 for a write burst, 0 for a read burst |
| stop | input | 1 | Terminates a full-row burst after the current beat |
| col | output | 8 | Column of the current beat |
| col_valid | output | 1 | A beat is present this cycle |
| last_beat | output | 1 | Current beat is the final one |
| mode_err | output | 1 | Settings captured at the last start were illegal |

## Verification
The block holds three pieces of state: the captured base column, the beat counter and the captured length exponent. A corrupted base or counter shows up at `col` on the very beat where it occurs. A wrong length exponent shows up within one burst, either as a misplaced wrap point or as `last_beat` on the wrong beat. A stuck active flag shows up on the cycle after the final beat, as a stray or missing `col_valid`. The bench therefore compares every beat of every burst, and the cycle after each burst, against a model of the requirements.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 8,
  parameter int MR_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MR_W-1:0]  mode_reg,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             wr,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             col_valid,
  output logic             last_beat,
  output logic             mode_err
);
  localparam int LGW = $clog2(COL_W + 1);
  localparam int BT_BIT = 3;
  localparam int WSB_BIT = 9;

  logic [LGW-1:0]   lg_d, lg_q;
  logic             full_d, err_d, full_q, il_q, active;
  logic [COL_W-1:0] base, beat, mask, seq_col, il_col;
  logic             end_beat;

  always_comb begin
    full_d = 1'b0;
    err_d  = 1'b0;
    lg_d   = '0;
    case (mode_reg[2:0])
      3'b000:  lg_d = LGW'(0);
      3'b001:  lg_d = LGW'(1);
      3'b010:  lg_d = LGW'(2);
      3'b011:  lg_d = LGW'(3);
      3'b111:  begin lg_d = LGW'(COL_W); full_d = 1'b1; end
      default: err_d = 1'b1;
    endcase
    if (full_d && mode_reg[BT_BIT]) begin
      err_d  = 1'b1;
      full_d = 1'b0;
      lg_d   = '0;
    end
    if (wr && mode_reg[WSB_BIT]) begin
      full_d = 1'b0;
      lg_d   = '0;
    end
  end

  assign mask     = ~({COL_W{1'b1}} << lg_q);
  assign seq_col  = (base & ~mask) | ((base + beat) & mask);
  assign il_col   = base ^ (beat & mask);
  assign col      = il_q ? il_col : seq_col;
  assign end_beat = full_q ? stop : (beat == mask);
  assign col_valid = active;
  assign last_beat = active & end_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      base     <= '0;
      beat     <= '0;
      lg_q     <= '0;
      full_q   <= 1'b0;
      il_q     <= 1'b0;
      mode_err <= 1'b0;
    end else if (start) begin
      active   <= 1'b1;
      base     <= start_col;
      beat     <= '0;
      lg_q     <= lg_d;
      full_q   <= full_d;
      il_q     <= mode_reg[BT_BIT];
      mode_err <= err_d;
    end else if (active) begin
      if (end_beat) active <= 1'b0;
      else          beat   <= beat + 1'b1;
    end
  end
endmodule

module sdram_burst_colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col,
  input logic             col_valid,
  input logic             last_beat,
  input logic             mode_err
);
  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col == $past(start_col)));
  p_ends_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> !col_valid);
  p_no_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !last_beat) |=> col_valid);
  p_last_is_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> col_valid);
  p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_err && col_valid) |-> last_beat);
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col), .col(col),
  .col_valid(col_valid), .last_beat(last_beat), .mode_err(mode_err));

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] mode_reg = '0;
  logic start = 1'b0, wr = 1'b0, stop = 1'b0;
  logic [7:0] start_col = '0;
  logic [7:0] col;
  logic col_valid, last_beat, mode_err;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sdram_burst_colgen u_dut (
    .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg), .start(start),
    .start_col(start_col), .wr(wr), .stop(stop), .col(col),
    .col_valid(col_valid), .last_beat(last_beat), .mode_err(mode_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_col(logic [7:0] b, int lg, bit il, int k);
    logic [7:0] m = 8'((1 << lg) - 1);
    logic [7:0] kk = 8'(k);
    if (il) return b ^ (kk & m);
    return (b & ~m) | ((b + kk) & m);
  endfunction

  // beats: number of beats to run before stop on a full row
  task automatic run_burst(input logic [2:0] code, input bit bt, input bit a9,
                           input bit w, input logic [7:0] b, input int beats);
    int lg; bit full, err, stopped;
    full = 0; err = 0; lg = 0;
    case (code)
      3'd0: lg = 0; 3'd1: lg = 1; 3'd2: lg = 2; 3'd3: lg = 3;
      3'd7: begin lg = 8; full = 1; end
      default: err = 1;
    endcase
    if (full && bt) begin err = 1; full = 0; lg = 0; end
    if (w && a9) begin full = 0; lg = 0; end
    @(negedge clk);
    mode_reg = {2'b00, a9, 5'b0, bt, code};
    wr = w; start_col = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    stopped = 0;
    for (int k = 0; !stopped; k++) begin
      bit lst;
      lst = full ? (k == beats - 1) : (k == (1 << lg) - 1);
      if (full && lst) stop = 1'b1;
      #1;
      if (k == 0) chk(mode_err == err, "R7", mode_err, err);
      chk(col_valid, "R2", col_valid, 1);
      chk(col == exp_col(b, lg, bt && !full, k), full ? "R5" : (bt ? "R4" : "R3"),
          col, exp_col(b, lg, bt && !full, k));
      chk(last_beat == lst, "R8", last_beat, lst);
      stopped = lst;
      @(negedge clk);
      stop = 1'b0;
    end
    #1;
    chk(!col_valid, "R8", col_valid, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(!col_valid && !last_beat && !mode_err, "R9", {col_valid, last_beat, mode_err}, 0);
    rst_n = 1'b1;
    // R1, R3: length 2, 4 sequential wraps
    run_burst(3'd1, 0, 0, 0, 8'h07, 0);
    run_burst(3'd2, 0, 0, 0, 8'h0E, 0);
    run_burst(3'd3, 0, 0, 1, 8'hFD, 0);
    run_burst(3'd0, 0, 0, 0, 8'h44, 0);
    // R4: interleaved length 8
    run_burst(3'd3, 1, 0, 0, 8'h35, 0);
    run_burst(3'd2, 1, 0, 1, 8'h9B, 0);
    // R5: full row past the 256 wrap, and a single-beat stop
    run_burst(3'd7, 0, 0, 0, 8'hFE, 260);
    run_burst(3'd7, 0, 0, 1, 8'h10, 1);
    // R7: reserved codes and full row with interleave
    run_burst(3'd4, 0, 0, 0, 8'h22, 0);
    run_burst(3'd6, 1, 0, 1, 8'h23, 0);
    run_burst(3'd7, 1, 0, 0, 8'h24, 0);
    run_burst(3'd1, 0, 0, 0, 8'h25, 0);
    // R6: single-beat write, read keeps length
    run_burst(3'd3, 0, 1, 1, 8'h50, 0);
    run_burst(3'd3, 0, 1, 0, 8'h50, 0);
    run_burst(3'd7, 0, 1, 1, 8'h51, 5);
    // R10: restart mid-burst
    @(negedge clk);
    mode_reg = 12'h003; wr = 1'b0; start_col = 8'h05; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    mode_reg = 12'h00A; start_col = 8'h21; start = 1'b1;
    #1;
    chk(col == 8'h06 && !last_beat, "R10", col, 6);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(col_valid && col == (8'h21 ^ 8'(k)), "R10", col, 8'h21 ^ 8'(k));
      chk(last_beat == (k == 3), "R10", last_beat, k == 3);
      @(negedge clk);
    end
    #1;
    chk(!col_valid, "R10", col_valid, 0);
    // constrained random
    for (int i = 0; i < 80; i++) begin
      run_burst(3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                8'($urandom), 1 + int'($urandom % 40));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule